// File: doc/BRIEF.md
# CCD Vertical Charge-Transfer Sequencer

This block decides when a CCD area imager gets its vertical clock trains. It issues three kinds of train on three identical strobes: one for the image-area gate, one for the storage-area gate and one for the transfer gate. A flush train empties charge from the imager before a new exposure. A transfer train reads out the exposed frame. A refresh train is issued when the block comes out of reset or out of standby. Each train is a counted burst of pulses. The pulse rate comes from the master clock through one of two dividers, and the choice is latched when the train starts.

The exposure gate can come from two places, chosen by a select input. It can be the vertical-drive input itself, which gives one readout per field. It can also be an external exposure-control input, which allows variable integration. A falling edge of the gate while vertical drive is high starts a flush. A falling edge while vertical drive is low arms a transfer, and that transfer starts once vertical drive is seen high. Standby gates every strobe low and aborts any train in progress. Leaving standby starts a refresh, and a transfer follows it automatically.

Top module: `ccd_vxfer_seq`

## Requirements
- R1: When `gate_sel_i` is high, the effective gate is `vd_i` and `gp_ext_i` has no effect. When it is low, the effective gate is `gp_ext_i`.
- R2: A falling edge of the effective gate, sampled while `vd_i` is high and no train is running, starts a flush train of FLUSH_LEN pulses on the next clock.
- R3: A falling edge of the effective gate, sampled while `vd_i` is low and no train is running, arms a transfer. The transfer train of XFER_LEN pulses starts on the first clock edge at which `vd_i` is sampled high. No pulse is issued before that edge.
- R4: Trains are started only by gate edges. A gate that stays high (integration) or stays low produces no further train.
- R5: On the first clock after reset release with `sb_i` high, and on each rising edge of `sb_i`, a refresh train of REFRESH_LEN pulses starts. A transfer train of XFER_LEN pulses follows it with no idle cycle between, whatever the gate inputs are.
- R6: While `sb_i` is low, all three strobes are low at once. A running train is aborted without a done strobe, and an armed transfer is discarded.
- R7: A pulse period is DIV_FAST clocks when `fast_i` is high and DIV_SLOW clocks when it is low. The strobe is high for the first period/2 (rounded down) clocks of each period. The rate is latched at the train's start, so a later change of `fast_i` does not affect that train.
- R8: `pi_o`, `ps_o` and `tg_o` are equal in every cycle.
- R9: A start request (gate edge) that arrives while a train is running is dropped, not queued.
- R10: `done_o` is high for exactly one clock after the last period of each completed train. While a train runs, `kind_o` reads 1 for flush, 2 for transfer and 3 for refresh, and `busy_o` is high. When idle, `kind_o` reads 0.
- R11: During reset, all strobes, `busy_o` and `done_o` are low and `kind_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd_i | input | 1 | Vertical-drive pulse, active low |
| gp_ext_i | input | 1 | External exposure gate |
| gate_sel_i | input | 1 | 1: gate follows vd_i; 0: gate is gp_ext_i |
| fast_i | input | 1 | Dump rate select: 1 fast divider, 0 slow divider |
| sb_i | input | 1 | 1: operate; 0: standby |
| pi_o | output | 1 | Image-area gate strobe |
| ps_o | output | 1 | Storage-area gate strobe |
| tg_o | output | 1 | Transfer-gate strobe |
| busy_o | output | 1 | A train is running |
| kind_o | output | 2 | Kind of the running train (0 idle, 1 flush, 2 transfer, 3 refresh) |
| done_o | output | 1 | One-clock strobe at the end of each train |

## Verification
The bench checks pulse counts, busy lengths and high-time totals against length × divider arithmetic for every kind of train at both rates. A design that counted one pulse too many or too few, or that ended the train on the wrong divider phase, would change those totals. The bench also covers the handover from refresh to transfer: a design that inserted an idle cycle there, or credited the first transfer pulse to the refresh, would show the wrong counts on either side of the done strobe. A transfer is armed while vertical drive is low and must not fire early, and a gate edge during a train must be dropped; a queuing design would emit an extra train. Standby raised in the middle of a train must silence the strobes at once, suppress the done strobe and discard an armed transfer.

// File: rtl/ccd_vx_pkg.sv
package ccd_vx_pkg;
  typedef enum logic [1:0] {
    TR_NONE    = 2'd0,
    TR_FLUSH   = 2'd1,
    TR_XFER    = 2'd2,
    TR_REFRESH = 2'd3
  } train_e;
endpackage

// File: rtl/ccd_vx_events.sv
// Input edge detection and start-request generation.
module ccd_vx_events (
  input  logic clk,
  input  logic rst_n,
  input  logic vd_i,
  input  logic gp_ext_i,
  input  logic gate_sel_i,
  input  logic sb_i,
  input  logic busy_i,
  output logic req_flush_o,
  output logic req_xfer_o,
  output logic req_refresh_o
);
  logic gate_eff;
  logic gate_q, gate_d;
  logic sb_q, sb_d;
  logic arm_q, arm_d;
  logic gate_fall;

  assign gate_eff  = gate_sel_i ? vd_i : gp_ext_i;
  assign gate_fall = gate_q & ~gate_eff;

  assign req_refresh_o = sb_i & ~sb_q;
  assign req_flush_o   = sb_i & ~busy_i & gate_fall & vd_i;
  assign req_xfer_o    = sb_i & ~busy_i & arm_q & vd_i;

  always_comb begin
    gate_d = gate_eff;
    sb_d   = sb_i;
    arm_d  = arm_q;
    if (!sb_i) begin
      arm_d = 1'b0;
    end else if (req_xfer_o || req_refresh_o) begin
      arm_d = 1'b0;
    end else if (!busy_i && gate_fall && !vd_i) begin
      arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      sb_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      sb_q   <= sb_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/ccd_vx_rate.sv
// Pulse-period divider with the rate latched at restart.
module ccd_vx_rate #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o,
  output logic phase_hi_o
);
  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int DW   = $clog2(DMAX + 1);
  localparam logic [DW-1:0] LAST_FAST = DW'(DIV_FAST - 1);
  localparam logic [DW-1:0] LAST_SLOW = DW'(DIV_SLOW - 1);
  localparam logic [DW-1:0] HI_FAST   = DW'(DIV_FAST / 2);
  localparam logic [DW-1:0] HI_SLOW   = DW'(DIV_SLOW / 2);

  logic [DW-1:0] div_q, div_d;
  logic          fast_q, fast_d;
  logic [DW-1:0] last_sel, hi_sel;

  assign last_sel   = fast_q ? LAST_FAST : LAST_SLOW;
  assign hi_sel     = fast_q ? HI_FAST : HI_SLOW;
  assign tick_o     = (div_q == last_sel);
  assign phase_hi_o = (div_q < hi_sel);

  always_comb begin
    div_d  = div_q;
    fast_d = fast_q;
    if (restart_i) begin
      div_d  = '0;
      fast_d = fast_i;
    end else if (run_i) begin
      div_d = tick_o ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      fast_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      fast_q <= fast_d;
    end
  end
endmodule

// File: rtl/ccd_vx_train.sv
// Train state machine and pulse counter.
module ccd_vx_train
  import ccd_vx_pkg::*;
#(
  parameter int FLUSH_LEN   = 302,
  parameter int XFER_LEN    = 290,
  parameter int REFRESH_LEN = 1026
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sb_i,
  input  logic   req_flush_i,
  input  logic   req_xfer_i,
  input  logic   req_refresh_i,
  input  logic   tick_i,
  output logic   restart_o,
  output logic   done_o,
  output train_e kind_o
);
  localparam int LMAX0 = (FLUSH_LEN > XFER_LEN) ? FLUSH_LEN : XFER_LEN;
  localparam int LMAX  = (LMAX0 > REFRESH_LEN) ? LMAX0 : REFRESH_LEN;
  localparam int CW    = $clog2(LMAX + 1);
  localparam logic [CW-1:0] END_FLUSH   = CW'(FLUSH_LEN - 1);
  localparam logic [CW-1:0] END_XFER    = CW'(XFER_LEN - 1);
  localparam logic [CW-1:0] END_REFRESH = CW'(REFRESH_LEN - 1);

  train_e        cur_q, cur_d;
  logic [CW-1:0] pcnt_q, pcnt_d;
  logic          done_q, done_d;
  logic [CW-1:0] end_sel;

  always_comb begin
    unique case (cur_q)
      TR_FLUSH:   end_sel = END_FLUSH;
      TR_XFER:    end_sel = END_XFER;
      TR_REFRESH: end_sel = END_REFRESH;
      default:    end_sel = '0;
    endcase
  end

  always_comb begin
    cur_d     = cur_q;
    pcnt_d    = pcnt_q;
    done_d    = 1'b0;
    restart_o = 1'b0;
    if (!sb_i) begin
      cur_d  = TR_NONE;
      pcnt_d = '0;
    end else if (cur_q == TR_NONE) begin
      pcnt_d = '0;
      if (req_refresh_i) begin
        cur_d     = TR_REFRESH;
        restart_o = 1'b1;
      end else if (req_flush_i) begin
        cur_d     = TR_FLUSH;
        restart_o = 1'b1;
      end else if (req_xfer_i) begin
        cur_d     = TR_XFER;
        restart_o = 1'b1;
      end
    end else if (tick_i) begin
      if (pcnt_q == end_sel) begin
        done_d = 1'b1;
        pcnt_d = '0;
        if (cur_q == TR_REFRESH) begin
          cur_d     = TR_XFER;
          restart_o = 1'b1;
        end else begin
          cur_d = TR_NONE;
        end
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= TR_NONE;
      pcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      pcnt_q <= pcnt_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign kind_o = cur_q;
endmodule

// File: rtl/ccd_vxfer_seq.sv
module ccd_vxfer_seq
  import ccd_vx_pkg::*;
#(
  parameter int FLUSH_LEN   = 302,
  parameter int XFER_LEN    = 290,
  parameter int REFRESH_LEN = 1026,
  parameter int DIV_FAST    = 4,
  parameter int DIV_SLOW    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vd_i,
  input  logic       gp_ext_i,
  input  logic       gate_sel_i,
  input  logic       fast_i,
  input  logic       sb_i,
  output logic       pi_o,
  output logic       ps_o,
  output logic       tg_o,
  output logic       busy_o,
  output logic [1:0] kind_o,
  output logic       done_o
);
  logic   req_flush, req_xfer, req_refresh;
  logic   restart, tick, phase_hi;
  train_e kind;
  logic   strobe;

  assign busy_o = (kind != TR_NONE);
  assign kind_o = kind;
  assign strobe = busy_o & sb_i & phase_hi;
  assign pi_o   = strobe;
  assign ps_o   = strobe;
  assign tg_o   = strobe;

  ccd_vx_events u_events (
    .clk          (clk),
    .rst_n        (rst_n),
    .vd_i         (vd_i),
    .gp_ext_i     (gp_ext_i),
    .gate_sel_i   (gate_sel_i),
    .sb_i         (sb_i),
    .busy_i       (busy_o),
    .req_flush_o  (req_flush),
    .req_xfer_o   (req_xfer),
    .req_refresh_o(req_refresh)
  );

  ccd_vx_rate #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW)
  ) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (busy_o),
    .fast_i    (fast_i),
    .tick_o    (tick),
    .phase_hi_o(phase_hi)
  );

  ccd_vx_train #(
    .FLUSH_LEN  (FLUSH_LEN),
    .XFER_LEN   (XFER_LEN),
    .REFRESH_LEN(REFRESH_LEN)
  ) u_train (
    .clk          (clk),
    .rst_n        (rst_n),
    .sb_i         (sb_i),
    .req_flush_i  (req_flush),
    .req_xfer_i   (req_xfer),
    .req_refresh_i(req_refresh),
    .tick_i       (tick),
    .restart_o    (restart),
    .done_o       (done_o),
    .kind_o       (kind)
  );
endmodule

// File: rtl/ccd_vxfer_seq_chk.sv
module ccd_vxfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sb_i,
  input logic       pi_o,
  input logic       ps_o,
  input logic       tg_o,
  input logic       busy_o,
  input logic [1:0] kind_o,
  input logic       done_o
);
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  // R6
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_i |-> (!pi_o && !ps_o && !tg_o));

  // R6
  standby_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sb_i |=> !busy_o);

  // R10
  idle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (kind_o == 2'd0 && !pi_o));
endmodule

bind ccd_vxfer_seq ccd_vxfer_seq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sb_i  (sb_i),
  .pi_o  (pi_o),
  .ps_o  (ps_o),
  .tg_o  (tg_o),
  .busy_o(busy_o),
  .kind_o(kind_o),
  .done_o(done_o)
);

// File: tb/ccd_vxfer_seq_bench.sv
module ccd_vxfer_seq_bench;
  localparam int FL = 5;
  localparam int XL = 3;
  localparam int RL = 9;
  localparam int DF = 4;
  localparam int DS = 7;

  logic clk = 1'b0;
  logic rst_n, vd, gp, gsel, fast, sb;
  logic pi, ps, tg, busy, done;
  logic [1:0] kind;

  always #4 clk = ~clk;

  ccd_vxfer_seq #(
    .FLUSH_LEN(FL), .XFER_LEN(XL), .REFRESH_LEN(RL),
    .DIV_FAST(DF), .DIV_SLOW(DS)
  ) u_ccd_vxfer_seq (
    .clk(clk), .rst_n(rst_n), .vd_i(vd), .gp_ext_i(gp), .gate_sel_i(gsel),
    .fast_i(fast), .sb_i(sb), .pi_o(pi), .ps_o(ps), .tg_o(tg),
    .busy_o(busy), .kind_o(kind), .done_o(done)
  );

  int tests = 0, fails = 0;
  int m_busy = 0, m_hi = 0, m_rise = 0, m_kind = 0;
  int r_busy = 0, r_hi = 0, r_rise = 0, r_kind = 0;
  int done_total = 0, eq_err = 0, sb_viol = 0;
  logic pi_prev = 1'b0;

  always @(negedge clk) begin
    if (!sb && (pi || ps || tg)) sb_viol++;
    if (pi != ps || ps != tg) eq_err++;
    if (!rst_n || !sb) begin
      m_busy = 0; m_hi = 0; m_rise = 0; pi_prev = 1'b0;
    end else begin
      if (done) begin
        done_total++;
        r_busy = m_busy; r_hi = m_hi; r_rise = m_rise; r_kind = m_kind;
        m_busy = 0; m_hi = 0; m_rise = 0;
      end
      if (busy) begin m_busy++; m_kind = int'(kind); end
      if (pi) m_hi++;
      if (pi && !pi_prev) m_rise++;
      pi_prev = pi;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_done(input string tag);
    int d0 = done_total;
    for (int i = 0; i < 2000; i++) begin
      if (done_total != d0) break;
      step(1);
    end
    check(done_total != d0, tag, done_total - d0, 1);
  endtask

  task automatic check_train(input string tag, input int k, input int len, input int div);
    check(r_kind == k, {tag, " kind"}, r_kind, k);
    check(r_rise == len, {tag, " pulses"}, r_rise, len);
    check(r_busy == len * div, {tag, " busy cycles"}, r_busy, len * div);
    check(r_hi == len * (div / 2), {tag, " high cycles"}, r_hi, len * (div / 2));
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0;
    rst_n = 1'b0; sb = 1'b1; gsel = 1'b0; gp = 1'b1; vd = 1'b1; fast = 1'b0;
    step(3);
    // R11 reset state
    check(!pi && !busy && !done && kind == 2'd0, "R11 reset outputs", {pi, busy, done}, 0);
    rst_n = 1'b1;
    step(1);
    // R5 refresh starts right after reset release
    check(busy && kind == 2'd3, "R5 refresh start", int'(kind), 3);
    wait_done("R5 refresh done");
    check_train("R5 R7 refresh slow", 3, RL, DS);
    wait_done("R5 chained transfer done");
    check_train("R5 chained transfer", 2, XL, DS);

    // R2 flush at fast rate, R7 rate latched, R9 requests dropped
    fast = 1'b1; step(10);
    gp = 1'b0;
    step(3);
    fast = 1'b0; gp = 1'b1; step(1); gp = 1'b0;
    d0 = done_total;
    wait_done("R2 flush done");
    check_train("R2 R7 flush fast", 1, FL, DF);
    step(80);
    check(done_total == d0 + 1, "R9 edge during train dropped", done_total - d0, 1);

    // R4 gate held low, then held high: no train
    d0 = done_total;
    step(60); gp = 1'b1; step(60);
    check(done_total == d0 && !busy, "R4 no edge no train", done_total - d0, 0);

    // R3 transfer armed while vd low, starts when vd high
    vd = 1'b0; step(1); gp = 1'b0; step(30);
    check(!busy && !pi, "R3 no pulse before vd high", int'(busy), 0);
    vd = 1'b1; step(1);
    check(busy && kind == 2'd2, "R3 transfer start", int'(kind), 2);
    wait_done("R3 transfer done");
    check_train("R3 transfer slow", 2, XL, DS);

    // R1 gate follows vd; external gate ignored
    gp = 1'b1; step(2); gsel = 1'b1; d0 = done_total;
    for (int i = 0; i < 6; i++) begin gp = ~gp; step(5); end
    step(40);
    check(done_total == d0 && !busy, "R1 external gate ignored", done_total - d0, 0);
    vd = 1'b0; step(5); vd = 1'b1;
    wait_done("R1 vd-driven transfer done");
    check_train("R1 vd-driven transfer", 2, XL, DS);

    // R6 standby aborts train, discards arm; R5 refresh on exit
    gsel = 1'b0; gp = 1'b1; step(3);
    gp = 1'b0; step(6);
    d0 = done_total;
    sb = 1'b0; #1;
    check(!pi && !ps && !tg, "R6 strobes low in standby", int'(pi), 0);
    step(1);
    check(!busy, "R6 train aborted", int'(busy), 0);
    vd = 1'b0; gp = 1'b1; step(2); gp = 1'b0; step(20);
    check(done_total == d0, "R6 no done on abort", done_total - d0, 0);
    sb = 1'b1;
    wait_done("R5 refresh after standby");
    check_train("R5 refresh after standby", 3, RL, DS);
    wait_done("R5 transfer after standby refresh");
    vd = 1'b1; d0 = done_total; step(80);
    check(done_total == d0 && !busy, "R6 armed transfer discarded", done_total - d0, 0);

    // R8 strobes identical, R6 silence throughout
    check(eq_err == 0, "R8 strobes equal", eq_err, 0);
    check(sb_viol == 0, "R6 standby silence", sb_viol, 0);
    finish_run();
  end
endmodule